// File: doc/BRIEF.md
# Strided Burst Memory Access Unit

A word-addressed storage unit that serves single and strided multi-word accesses. Work arrives on handshaked channels for address, write data, stride and count. Each address token carries a two-bit operation tag above its address field. A single read returns one stored word. A single write stores one word and answers with a zero acknowledgement. A burst walks from a start address by a fixed stride for a given number of elements and produces one response per element. The response channel is the only output path for memory results.

A separate code-descriptor channel has priority over all memory work. While a descriptor is offered, no memory operation starts. Accepted descriptors go into a one-entry slot and are presented on a side output with their size and base fields already split apart. Decoding the descriptor is left to whatever consumes that side output.

The controller is a three-state machine:
- `ST_IDLE` waits for a command. A single read or a single write moves it to `ST_HOLD`. A burst with a nonzero count moves it to `ST_ELEM`. A zero-count burst leaves it in `ST_IDLE`.
- `ST_ELEM` issues one burst element and then moves to `ST_HOLD`.
- `ST_HOLD` presents the response. When the response is taken, it goes back to `ST_ELEM` if elements remain, and to `ST_IDLE` otherwise.

Top module: `sbm_unit`

## Requirements
- R1: The operation is chosen by `adr_data[DW+1:DW]`. The codes are 2'b00 single read, 2'b01 single write, 2'b10 burst read and 2'b11 burst write. The word address is `adr_data[AW-1:0]`.
- R2: A single read is accepted when the address token is valid and no other work is active. `rsp_valid` rises on the clock edge after acceptance, and the data is the word stored at that address.
- R3: A single write is accepted only when an address token and a write-data token are valid in the same cycle. It consumes both tokens, stores the word and responds with 0. Without write data, `adr_ready` stays low.
- R4: A burst is accepted only when the address, stride and count tokens are all valid, and all three are consumed in the same cycle. A burst with count 0 produces no response.
- R5: Burst element i uses address start + i*stride, computed modulo 2^AW.
- R6: A burst write consumes one write-data token per element, stores it at the element address and responds 0 for each element.
- R7: A burst read responds with the stored word for each element, in element order.
- R8: While burst elements remain, `adr_ready` stays low.
- R9: While `cd_valid` is high, no memory operation starts: `adr_ready` and `wd_ready` stay low.
- R10: An accepted descriptor appears on `cq_valid`. `cq_size` is `cd_data[5:0]` and `cq_base` is `cd_data[DW-1:6]`. The entry is held until `cq_ready` is high. `cd_ready` is low while the slot is full.
- R11: Once `rsp_valid` is high, it and `rsp_data` stay unchanged until `rsp_ready` is high.
- R12: After reset, `rsp_valid` and `cq_valid` are low and `cd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adr_valid | input | 1 | Address token valid |
| adr_ready | output | 1 | Address token accepted |
| adr_data | input | DW+2 | Operation tag and address |
| wd_valid | input | 1 | Write-data token valid |
| wd_ready | output | 1 | Write-data token accepted |
| wd_data | input | DW | Word to store |
| str_valid | input | 1 | Stride token valid |
| str_ready | output | 1 | Stride token accepted |
| str_data | input | DW | Burst stride |
| cnt_valid | input | 1 | Count token valid |
| cnt_ready | output | 1 | Count token accepted |
| cnt_data | input | DW | Burst element count |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | DW | Read word, or 0 for a write acknowledgement |
| cd_valid | input | 1 | Code descriptor valid |
| cd_ready | output | 1 | Code descriptor accepted |
| cd_data | input | DW | Code descriptor |
| cq_valid | output | 1 | Queued descriptor valid |
| cq_ready | input | 1 | Queued descriptor taken |
| cq_base | output | DW-6 | Descriptor base field |
| cq_size | output | 6 | Descriptor size field |

## Verification
Single accesses are tried in three ways: a write followed by a read-back, which separates a store from an acknowledgement alone; a write offered without data, which shows the pairing rule; and a held response, which shows that the output stalls correctly. Bursts are tried with a positive stride, a negative stride and a stride that wraps past the top of the address space, and every element is read back singly, so a wrong step or a wrong element count shows up as a mismatched word. A zero-count burst and a single command presented during a burst separate the rules on consuming tokens from the rule that a burst holds the unit. A descriptor offered at the same time as a memory command shows its priority, its field split and the back-pressure of its one-entry slot.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_BRD = 2'b10,
        OP_BWR = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ELEM = 2'd1,
        ST_HOLD = 2'd2
    } st_e;
endpackage

// File: rtl/sbm_ram.sv
module sbm_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/sbm_cdq.sv
module sbm_cdq #(
    parameter int DW  = 32,
    parameter int SZW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_data,
    output logic              q_valid,
    input  logic              q_ready,
    output logic [DW-SZW-1:0] q_base,
    output logic [SZW-1:0]    q_size
);
    logic full_q;

    assign in_ready = !full_q;
    assign q_valid  = full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            q_base <= '0;
            q_size <= '0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            q_size <= in_data[SZW-1:0];
            q_base <= in_data[DW-1:SZW];
        end else if (full_q && q_ready) begin
            full_q <= 1'b0;
        end
    end

    a_r10_q_hold: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid && !q_ready |=> q_valid && $stable(q_base) && $stable(q_size));
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
    import sbm_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adr_valid,
    output logic          adr_ready,
    input  logic [1:0]    adr_tag,
    input  logic [AW-1:0] adr_addr,
    input  logic          wd_valid,
    output logic          wd_ready,
    input  logic          str_valid,
    output logic          str_ready,
    input  logic [AW-1:0] str_lo,
    input  logic          cnt_valid,
    output logic          cnt_ready,
    input  logic [DW-1:0] cnt_data,
    input  logic          cd_valid,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic          ack_sel,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr
);
    st_e           st, st_nxt;
    op_e           tag;
    logic          go, idle_go, burst_tag;
    logic          take_rd, take_wr, take_bu, elem_rd, elem_wr;
    logic [AW-1:0] cur_q, stp_q;
    logic [DW-1:0] rem_q;
    logic          bwr_q, ack_q;

    // decode and handshake outputs
    always_comb begin
        tag       = op_e'(adr_tag);
        burst_tag = (tag == OP_BRD) || (tag == OP_BWR);
        go        = (st != ST_HOLD) && !cd_valid;
        idle_go   = go && (st == ST_IDLE) && adr_valid;
        take_rd   = idle_go && (tag == OP_RD);
        take_wr   = idle_go && (tag == OP_WR) && wd_valid;
        take_bu   = idle_go && burst_tag && str_valid && cnt_valid;
        elem_rd   = go && (st == ST_ELEM) && !bwr_q;
        elem_wr   = go && (st == ST_ELEM) && bwr_q && wd_valid;
        adr_ready = take_rd || take_wr || take_bu;
        wd_ready  = take_wr || elem_wr;
        str_ready = take_bu;
        cnt_ready = take_bu;
        mem_re    = take_rd || elem_rd;
        mem_we    = take_wr || elem_wr;
        mem_addr  = (st == ST_ELEM) ? cur_q : adr_addr;
        rsp_valid = (st == ST_HOLD);
        ack_sel   = ack_q;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (take_rd || take_wr)                st_nxt = ST_HOLD;
                else if (take_bu && cnt_data != '0)    st_nxt = ST_ELEM;
            end
            ST_ELEM: if (elem_rd || elem_wr)           st_nxt = ST_HOLD;
            ST_HOLD: if (rsp_ready) st_nxt = (rem_q != '0) ? ST_ELEM : ST_IDLE;
            default:                                   st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // burst walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            stp_q <= '0;
            rem_q <= '0;
            bwr_q <= 1'b0;
            ack_q <= 1'b0;
        end else if (take_bu) begin
            cur_q <= adr_addr;
            stp_q <= str_lo;
            rem_q <= cnt_data;
            bwr_q <= (tag == OP_BWR);
        end else if (take_rd || take_wr) begin
            ack_q <= take_wr;
        end else if (elem_rd || elem_wr) begin
            cur_q <= cur_q + stp_q;
            rem_q <= rem_q - 1'b1;
            ack_q <= bwr_q;
        end
    end

    a_r9_desc_first: assert property (@(posedge clk) disable iff (!rst_n)
        cd_valid |-> !adr_ready && !wd_ready);
    a_r8_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q != '0 |-> !adr_ready);
    a_r4_three_tokens: assert property (@(posedge clk) disable iff (!rst_n)
        adr_ready && adr_tag[1] |-> str_valid && cnt_valid);
    a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid);
    a_r2_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        adr_ready && adr_tag == 2'b00 |=> rsp_valid);
endmodule

// File: rtl/sbm_unit.sv
module sbm_unit #(
    parameter int DW  = 32,
    parameter int AW  = 8,
    parameter int SZW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adr_valid,
    output logic              adr_ready,
    input  logic [DW+1:0]     adr_data,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DW-1:0]     wd_data,
    input  logic              str_valid,
    output logic              str_ready,
    input  logic [DW-1:0]     str_data,
    input  logic              cnt_valid,
    output logic              cnt_ready,
    input  logic [DW-1:0]     cnt_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DW-1:0]     rsp_data,
    input  logic              cd_valid,
    output logic              cd_ready,
    input  logic [DW-1:0]     cd_data,
    output logic              cq_valid,
    input  logic              cq_ready,
    output logic [DW-SZW-1:0] cq_base,
    output logic [SZW-1:0]    cq_size
);
    logic          mem_we, mem_re, ack_sel;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] rd_word;
    logic          unused_hi;

    assign unused_hi = ^{adr_data[DW-1:AW], str_data[DW-1:AW]};

    sbm_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .adr_valid(adr_valid), .adr_ready(adr_ready),
        .adr_tag(adr_data[DW+1:DW]), .adr_addr(adr_data[AW-1:0]),
        .wd_valid(wd_valid), .wd_ready(wd_ready),
        .str_valid(str_valid), .str_ready(str_ready), .str_lo(str_data[AW-1:0]),
        .cnt_valid(cnt_valid), .cnt_ready(cnt_ready), .cnt_data(cnt_data),
        .cd_valid(cd_valid),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .ack_sel(ack_sel),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
    );

    sbm_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
        .wdata(wd_data), .rdata(rd_word)
    );

    sbm_cdq #(.DW(DW), .SZW(SZW)) u_cdq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(cd_valid), .in_ready(cd_ready), .in_data(cd_data),
        .q_valid(cq_valid), .q_ready(cq_ready), .q_base(cq_base), .q_size(cq_size)
    );

    assign rsp_data = ack_sel ? '0 : rd_word;

    a_r11_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> $stable(rsp_data));
endmodule

// File: tb/sim_sbm_unit.sv
`timescale 1ns/1ps
module sim_sbm_unit;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [1:0] T_RD = 2'b00, T_WR = 2'b01, T_BRD = 2'b10, T_BWR = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic adr_valid = 0, wd_valid = 0, str_valid = 0, cnt_valid = 0;
    logic rsp_ready = 0, cd_valid = 0, cq_ready = 0;
    logic [DW+1:0] adr_data = '0;
    logic [DW-1:0] wd_data = '0, str_data = '0, cnt_data = '0, cd_data = '0;
    logic adr_ready, wd_ready, str_ready, cnt_ready, rsp_valid, cd_ready, cq_valid;
    logic [DW-1:0] rsp_data;
    logic [DW-7:0] cq_base;
    logic [5:0]    cq_size;

    int total = 0, bad = 0;
    logic [DW-1:0] mdl [1<<AW];

    always #2.5 clk = ~clk;

    sbm_unit #(.DW(DW), .AW(AW), .SZW(6)) u0 (.*);

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] tag, logic [AW-1:0] a, logic [DW-1:0] wd,
                         logic [DW-1:0] s, logic [DW-1:0] c);
        @(negedge clk);
        adr_valid = 1; adr_data = {tag, DW'(a)};
        wd_valid = (tag == T_WR); wd_data = wd;
        str_valid = tag[1]; str_data = s;
        cnt_valid = tag[1]; cnt_data = c;
        #1;
        while (!adr_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        adr_valid = 0; wd_valid = 0; str_valid = 0; cnt_valid = 0;
    endtask

    task automatic push_wd(logic [DW-1:0] d);
        @(negedge clk);
        wd_valid = 1; wd_data = d; #1;
        while (!wd_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        wd_valid = 0;
    endtask

    task automatic take_rsp(string req, logic [DW-1:0] exp);
        @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        check(req, rsp_data, exp);
        rsp_ready = 1;
        @(posedge clk); #1;
        rsp_ready = 0;
    endtask

    task automatic t_reset();
        check("R12 rsp_valid", DW'(rsp_valid), 0);
        check("R12 cq_valid", DW'(cq_valid), 0);
        check("R12 cd_ready", DW'(cd_ready), 1);
    endtask

    task automatic t_single();
        issue(T_WR, 8'd5, 32'hCAFE_0005, 0, 0); mdl[5] = 32'hCAFE_0005;
        take_rsp("R3 write ack", 0);
        issue(T_RD, 8'd5, 0, 0, 0);
        check("R2 latency", DW'(rsp_valid), 1);
        take_rsp("R1 R2 read data", 32'hCAFE_0005);
    endtask

    task automatic t_write_needs_data();
        @(negedge clk);
        adr_valid = 1; adr_data = {T_WR, DW'(9)}; wd_valid = 0; #1;
        check("R3 no data no accept", DW'(adr_ready), 0);
        adr_data = {T_BRD, DW'(9)}; str_valid = 1; cnt_valid = 0; #1;
        check("R4 missing count", DW'(adr_ready), 0);
        @(negedge clk);
        adr_valid = 0; str_valid = 0;
    endtask

    task automatic t_hold();
        issue(T_RD, 8'd5, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R11 still valid", DW'(rsp_valid), 1);
        check("R11 data stable", rsp_data, 32'hCAFE_0005);
        take_rsp("R11 final", 32'hCAFE_0005);
    endtask

    task automatic t_burst_write(logic [AW-1:0] a, logic [DW-1:0] s, int n, logic [DW-1:0] seed);
        logic [AW-1:0] p = a;
        issue(T_BWR, a, 0, s, DW'(n));
        for (int i = 0; i < n; i++) begin
            push_wd(seed + DW'(i));
            mdl[p] = seed + DW'(i);
            take_rsp("R6 burst write ack", 0);
            p = p + s[AW-1:0];
        end
        p = a;
        for (int i = 0; i < n; i++) begin
            issue(T_RD, p, 0, 0, 0);
            take_rsp("R5 R6 stored at stride", seed + DW'(i));
            p = p + s[AW-1:0];
        end
    endtask

    task automatic t_burst_read(logic [AW-1:0] a, logic [DW-1:0] s, int n);
        logic [AW-1:0] p = a;
        issue(T_BRD, a, 0, s, DW'(n));
        for (int i = 0; i < n; i++) begin
            take_rsp("R7 burst read word", mdl[p]);
            p = p + s[AW-1:0];
        end
    endtask

    task automatic t_burst_blocks();
        issue(T_BRD, 8'd10, 0, 3, 4);
        @(negedge clk);
        adr_valid = 1; adr_data = {T_RD, DW'(5)}; #1;
        check("R8 blocked in burst", DW'(adr_ready), 0);
        adr_valid = 0;
        for (int i = 0; i < 4; i++) take_rsp("R7 burst after block", mdl[8'(10 + 3*i)]);
    endtask

    task automatic t_zero_count();
        issue(T_BRD, 8'd5, 0, 1, 0);
        repeat (2) @(negedge clk);
        check("R4 zero count no rsp", DW'(rsp_valid), 0);
        issue(T_RD, 8'd5, 0, 0, 0);
        take_rsp("R4 free after zero count", mdl[5]);
    endtask

    task automatic t_desc();
        @(negedge clk);
        cd_valid = 1; cd_data = {26'h12345, 6'd17};
        adr_valid = 1; adr_data = {T_RD, DW'(5)}; #1;
        check("R9 adr blocked", DW'(adr_ready), 0);
        check("R9 cd ready", DW'(cd_ready), 1);
        @(posedge clk); #1;
        cd_data = {26'h2AAAA, 6'd63};
        check("R10 queued", DW'(cq_valid), 1);
        check("R10 base", DW'(cq_base), 32'h12345);
        check("R10 size", DW'(cq_size), 17);
        check("R10 slot full", DW'(cd_ready), 0);
        check("R9 still blocked", DW'(adr_ready), 0);
        adr_valid = 0;
        @(negedge clk); cq_ready = 1;
        @(posedge clk); #1; cq_ready = 0;
        @(posedge clk); #1; cd_valid = 0;
        check("R10 second base", DW'(cq_base), 32'h2AAAA);
        check("R10 second size", DW'(cq_size), 63);
        cq_ready = 1; @(posedge clk); #1; cq_ready = 0;
        issue(T_RD, 8'd5, 0, 0, 0);
        take_rsp("R9 read after desc", mdl[5]);
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_write_needs_data();
        t_hold();
        t_burst_write(8'd10, 32'd3, 4, 32'h1000_0000);
        t_burst_read(8'd19, 32'hFFFF_FFFD, 4);
        t_burst_write(8'd250, 32'd4, 3, 32'h2000_0000);
        t_burst_read(8'd250, 32'd4, 3);
        t_burst_blocks();
        t_zero_count();
        t_desc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule